// File: doc/BRIEF.md
# Dual-Channel Transmitter Configuration Latch Bank

This block holds the configuration state of a two-channel serial transmitter in a small bank of 4-bit latches that a controller loads through a parallel write port made of an address, a data nibble and a write strobe. Each channel owns three latch slots. Two are static, and one of them carries the clock-select and rate controls. The third is dynamic and carries the transmit self-test control, the enables of the primary and secondary output drivers, and a phase-buffer re-center request. An active-low device reset, sampled on the system clock, returns every slot of both channels to its own default. In that state all output drivers are off.

From the latch contents the block derives the per-channel control outputs and a power-down flag for each driver. A channel whose two drivers are both disabled also gets a logic power-down flag. A re-center request is raised by writing 0 into the request bit. The request crosses into that channel's own transmit clock through a synchronizer, where it becomes a single pulse one transmit clock wide. A return handshake then sets the request bit back to its idle value of 1, so software never has to write it back.

Top module: `cfg_latch_bank`

## Requirements
- R1: A write takes effect on the rising system clock edge at which `wr_en` is 1. Channel 0 owns addresses 0, 1 and 2, and channel 1 owns addresses 9, 10 and 11, in that order: general static slot, rate/clock static slot, dynamic slot.
- R2: A system clock edge that samples `dev_rst_n` low loads 4'b1111 into both general slots, 4'b0110 into both rate/clock slots and 4'b1001 into both dynamic slots. As a result, all drivers and both channels report powered down, self-test is off, clock select reads 1 and rate reads 0.
- R3: In the rate/clock slot, bit 1 drives `clk_sel[ch]` and bit 0 drives `rate[ch]`. The full general slot of channel ch appears on `misc_cfg[4*ch+3:4*ch]`.
- R4: Bit 3 of the dynamic slot is an active-low self-test control: `bist_on[ch]` is the inverse of that bit.
- R5: Bit 1 of the dynamic slot enables the primary driver and bit 2 enables the secondary driver. `drv1_off[ch]` and `drv2_off[ch]` are 1 exactly when the matching enable bit is 0.
- R6: `chan_off[ch]` is 1 exactly when both driver enable bits of that channel are 0.
- R7: A write to any address outside {0,1,2,9,10,11}, or any cycle with `wr_en` at 0, changes no output.
- R8: Writing a dynamic slot with bit 0 at 0 produces exactly one pulse on `recenter_pulse[ch]`, one `tx_clk[ch]` period wide, in that channel only. The request bit then returns to 1 without a further write, so a later write of 0 produces another single pulse.
- R9: Writing a dynamic slot with bit 0 at 1 raises no re-center pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the write port and all latches |
| dev_rst_n | input | 1 | Device reset, active low, sampled on `clk` |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Latch address |
| wr_data | input | 4 | Data nibble to write |
| tx_clk | input | NUM_CH | Per-channel transmit clock, asynchronous to `clk` |
| misc_cfg | output | 4*NUM_CH | General static slot of each channel |
| clk_sel | output | NUM_CH | Transmit clock select per channel |
| rate | output | NUM_CH | Rate select per channel |
| bist_on | output | NUM_CH | Transmit self-test active per channel |
| drv1_off | output | NUM_CH | Primary driver powered down |
| drv2_off | output | NUM_CH | Secondary driver powered down |
| chan_off | output | NUM_CH | Channel logic powered down |
| recenter_pulse | output | NUM_CH | Phase-buffer re-center pulse, in the `tx_clk[ch]` domain |

## Verification
The hardest case to reach is the self-clear of the re-center request. The request bit is never visible at the ports, and the pulse it causes lives in a clock that drifts against the write clock. The stimulus therefore issues two consecutive writes of 0 to the same dynamic slot and a write that leaves bit 0 at 1, and counts pulse-high samples on each transmit clock after every write. The two transmit clocks run at periods unrelated to the system clock and to each other. Exactly one new sample on the right channel shows both the single-width pulse and the return of the request bit to idle.

// File: rtl/cfg_bank_pkg.sv
`timescale 1ns/1ps
package cfg_bank_pkg;

    localparam int NUM_CH    = 2;
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 4;
    localparam int CH_STRIDE = 9;

    localparam logic [DATA_W-1:0] RST_GEN  = 4'b1111;
    localparam logic [DATA_W-1:0] RST_RATE = 4'b0110;
    localparam logic [DATA_W-1:0] RST_DYN  = 4'b1001;

    typedef enum logic [1:0] {
        SLOT_GEN  = 2'd0,
        SLOT_RATE = 2'd1,
        SLOT_DYN  = 2'd2,
        SLOT_NONE = 2'd3
    } slot_e;

    // Dynamic slot layout, MSB first.
    typedef struct packed {
        logic bist_n;
        logic oe2;
        logic oe1;
        logic pab_n;
    } dyn_t;

    typedef struct packed {
        logic clk_sel;
        logic rate;
    } rate_t;

    function automatic logic [ADDR_W-1:0] chan_base(input int ch);
        return ADDR_W'(ch * CH_STRIDE);
    endfunction

    function automatic slot_e decode_slot(input logic [ADDR_W-1:0] addr, input int ch);
        logic [ADDR_W-1:0] base;
        base = chan_base(ch);
        if (addr == base)                      return SLOT_GEN;
        else if (addr == base + ADDR_W'(1))    return SLOT_RATE;
        else if (addr == base + ADDR_W'(2))    return SLOT_DYN;
        else                                   return SLOT_NONE;
    endfunction

endpackage

// File: rtl/cfg_chan_regs.sv
`timescale 1ns/1ps
module cfg_chan_regs
    import cfg_bank_pkg::*;
#(
    parameter int CH_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ack_sync,
    output logic [DATA_W-1:0] gen_q,
    output rate_t             rate_q,
    output dyn_t              dyn_q
);

    slot_e slot;
    dyn_t  wr_dyn;

    assign slot   = wr_en ? decode_slot(wr_addr, CH_IDX) : SLOT_NONE;
    assign wr_dyn = dyn_t'(wr_data);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_q  <= RST_GEN;
            rate_q <= rate_t'(RST_RATE[1:0]);
            dyn_q  <= dyn_t'(RST_DYN);
        end else begin
            if (slot == SLOT_GEN)
                gen_q <= wr_data;
            if (slot == SLOT_RATE)
                rate_q <= rate_t'(wr_data[1:0]);
            if (slot == SLOT_DYN) begin
                dyn_q.bist_n <= wr_dyn.bist_n;
                dyn_q.oe2    <= wr_dyn.oe2;
                dyn_q.oe1    <= wr_dyn.oe1;
            end
            // Request bit: only a written 0 arms it; the returning
            // acknowledge restores it to idle.
            if (ack_sync)
                dyn_q.pab_n <= 1'b1;
            else if (slot == SLOT_DYN && !wr_dyn.pab_n)
                dyn_q.pab_n <= 1'b0;
        end
    end

endmodule

// File: rtl/cfg_recenter_sync.sv
`timescale 1ns/1ps
module cfg_recenter_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic tx_clk,
    output logic ack_sync,
    output logic pulse
);

    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0]         tx_rst_pipe;
    logic                 tx_rst_n;
    logic [SYNC_STAGES:0] req_pipe;
    logic                 req_seen;
    logic                 req_prev;
    logic [MSB:0]         ack_pipe;

    // Reset brought into the transmit domain.
    always_ff @(posedge tx_clk)
        tx_rst_pipe <= {tx_rst_pipe[MSB-1:0], rst_n};
    assign tx_rst_n = tx_rst_pipe[MSB];

    assign req_seen = req_pipe[MSB];
    assign req_prev = req_pipe[SYNC_STAGES];

    always_ff @(posedge tx_clk) begin
        if (!tx_rst_n) begin
            req_pipe <= '0;
            pulse    <= 1'b0;
        end else begin
            req_pipe <= {req_pipe[SYNC_STAGES-1:0], req};
            pulse    <= req_seen & ~req_prev;
        end
    end

    // Acknowledge returned to the system clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ack_pipe <= '0;
        else
            ack_pipe <= {ack_pipe[MSB-1:0], req_seen};
    end
    assign ack_sync = ack_pipe[MSB];

endmodule

// File: rtl/cfg_latch_bank.sv
`timescale 1ns/1ps
module cfg_latch_bank
    import cfg_bank_pkg::*;
#(
    parameter int NUM_CHANNELS = NUM_CH,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                           clk,
    input  logic                           dev_rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic [NUM_CHANNELS-1:0]        tx_clk,
    output logic [NUM_CHANNELS*DATA_W-1:0] misc_cfg,
    output logic [NUM_CHANNELS-1:0]        clk_sel,
    output logic [NUM_CHANNELS-1:0]        rate,
    output logic [NUM_CHANNELS-1:0]        bist_on,
    output logic [NUM_CHANNELS-1:0]        drv1_off,
    output logic [NUM_CHANNELS-1:0]        drv2_off,
    output logic [NUM_CHANNELS-1:0]        chan_off,
    output logic [NUM_CHANNELS-1:0]        recenter_pulse
);

    for (genvar ch = 0; ch < NUM_CHANNELS; ch++) begin : g_ch
        logic [DATA_W-1:0] gen_q;
        rate_t             rate_q;
        dyn_t              dyn_q;
        logic              ack_sync;

        cfg_chan_regs #(.CH_IDX(ch)) u_regs (
            .clk      (clk),
            .rst_n    (dev_rst_n),
            .wr_en    (wr_en),
            .wr_addr  (wr_addr),
            .wr_data  (wr_data),
            .ack_sync (ack_sync),
            .gen_q    (gen_q),
            .rate_q   (rate_q),
            .dyn_q    (dyn_q)
        );

        cfg_recenter_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (dev_rst_n),
            .req      (~dyn_q.pab_n),
            .tx_clk   (tx_clk[ch]),
            .ack_sync (ack_sync),
            .pulse    (recenter_pulse[ch])
        );

        assign misc_cfg[ch*DATA_W +: DATA_W] = gen_q;
        assign clk_sel[ch]  = rate_q.clk_sel;
        assign rate[ch]     = rate_q.rate;
        assign bist_on[ch]  = ~dyn_q.bist_n;
        assign drv1_off[ch] = ~dyn_q.oe1;
        assign drv2_off[ch] = ~dyn_q.oe2;
        assign chan_off[ch] = ~(dyn_q.oe1 | dyn_q.oe2);
    end

endmodule

// File: rtl/cfg_latch_bank_chk.sv
`timescale 1ns/1ps
module cfg_latch_bank_chk
    import cfg_bank_pkg::*;
#(
    parameter int NUM_CHANNELS = NUM_CH
) (
    input logic                           clk,
    input logic                           dev_rst_n,
    input logic                           wr_en,
    input logic [ADDR_W-1:0]              wr_addr,
    input logic [DATA_W-1:0]              wr_data,
    input logic [NUM_CHANNELS-1:0]        tx_clk,
    input logic [NUM_CHANNELS*DATA_W-1:0] misc_cfg,
    input logic [NUM_CHANNELS-1:0]        clk_sel,
    input logic [NUM_CHANNELS-1:0]        rate,
    input logic [NUM_CHANNELS-1:0]        bist_on,
    input logic [NUM_CHANNELS-1:0]        drv1_off,
    input logic [NUM_CHANNELS-1:0]        drv2_off,
    input logic [NUM_CHANNELS-1:0]        chan_off,
    input logic [NUM_CHANNELS-1:0]        recenter_pulse
);

    for (genvar ch = 0; ch < NUM_CHANNELS; ch++) begin : g_chk
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(ch * CH_STRIDE);

        AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!dev_rst_n)
            $rose(dev_rst_n) |-> (drv1_off[ch] && drv2_off[ch] && chan_off[ch]
                                  && !bist_on[ch] && clk_sel[ch] && !rate[ch]))
            else $error("reset defaults wrong"); // R2

        AST_RATE_WRITE: assert property (@(posedge clk) disable iff (!dev_rst_n)
            (wr_en && wr_addr == BASE + ADDR_W'(1)) |=>
                (clk_sel[ch] == $past(wr_data[1]) && rate[ch] == $past(wr_data[0])))
            else $error("rate slot decode wrong"); // R3

        AST_BIST_WRITE: assert property (@(posedge clk) disable iff (!dev_rst_n)
            (wr_en && wr_addr == BASE + ADDR_W'(2)) |=> (bist_on[ch] == !$past(wr_data[3])))
            else $error("self-test polarity wrong"); // R4

        AST_DRV_WRITE: assert property (@(posedge clk) disable iff (!dev_rst_n)
            (wr_en && wr_addr == BASE + ADDR_W'(2)) |=>
                (drv1_off[ch] == !$past(wr_data[1]) && drv2_off[ch] == !$past(wr_data[2])))
            else $error("driver enable decode wrong"); // R5

        AST_DRV_HOLD: assert property (@(posedge clk) disable iff (!dev_rst_n)
            !(wr_en && wr_addr == BASE + ADDR_W'(2)) |=>
                ($stable(drv1_off[ch]) && $stable(drv2_off[ch]) && $stable(chan_off[ch])))
            else $error("driver state changed without write"); // R7

        AST_PULSE_ONE_WIDE: assert property (@(posedge tx_clk[ch]) disable iff (!dev_rst_n)
            recenter_pulse[ch] |=> !recenter_pulse[ch])
            else $error("re-center pulse wider than one cycle"); // R8
    end

endmodule

bind cfg_latch_bank cfg_latch_bank_chk #(.NUM_CHANNELS(NUM_CHANNELS)) u_chk (
    .clk            (clk),
    .dev_rst_n      (dev_rst_n),
    .wr_en          (wr_en),
    .wr_addr        (wr_addr),
    .wr_data        (wr_data),
    .tx_clk         (tx_clk),
    .misc_cfg       (misc_cfg),
    .clk_sel        (clk_sel),
    .rate           (rate),
    .bist_on        (bist_on),
    .drv1_off       (drv1_off),
    .drv2_off       (drv2_off),
    .chan_off       (chan_off),
    .recenter_pulse (recenter_pulse)
);

// File: tb/cfg_latch_bank_tb.sv
`timescale 1ns/1ps
module cfg_latch_bank_tb;
    import cfg_bank_pkg::*;

    localparam int NCH = 2;

    logic                  clk = 1'b0;
    logic                  dev_rst_n;
    logic                  wr_en;
    logic [ADDR_W-1:0]     wr_addr;
    logic [DATA_W-1:0]     wr_data;
    logic [NCH-1:0]        tx_clk = '0;
    logic [NCH*DATA_W-1:0] misc_cfg;
    logic [NCH-1:0]        clk_sel, rate, bist_on, drv1_off, drv2_off, chan_off, recenter_pulse;

    always #2.0 clk = ~clk;            // 250 MHz
    always #3.3 tx_clk[0] = ~tx_clk[0];
    always #5.7 tx_clk[1] = ~tx_clk[1];

    cfg_latch_bank u_dut (
        .clk(clk), .dev_rst_n(dev_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tx_clk(tx_clk), .misc_cfg(misc_cfg), .clk_sel(clk_sel),
        .rate(rate), .bist_on(bist_on), .drv1_off(drv1_off), .drv2_off(drv2_off),
        .chan_off(chan_off), .recenter_pulse(recenter_pulse)
    );

    typedef struct {
        logic [19:0] v;
        string       tag;
    } exp_t;

    exp_t   sb[$];
    int     checks = 0;
    int     errors = 0;
    bit     done   = 0;
    int     pcount [NCH];
    logic [3:0] m_gen [NCH];
    logic [3:0] m_rate[NCH];
    logic [3:0] m_dyn [NCH];

    function automatic logic [19:0] model_vec();
        logic [7:0] mc;
        logic [1:0] cs, rt, bi, d1, d2, co;
        for (int c = 0; c < NCH; c++) begin
            mc[c*4 +: 4] = m_gen[c];
            cs[c] = m_rate[c][1];
            rt[c] = m_rate[c][0];
            bi[c] = ~m_dyn[c][3];
            d1[c] = ~m_dyn[c][1];
            d2[c] = ~m_dyn[c][2];
            co[c] = ~m_dyn[c][1] & ~m_dyn[c][2];
        end
        return {mc, cs, rt, bi, d1, d2, co};
    endfunction

    function automatic void model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_gen[c]  = 4'b1111;
            m_rate[c] = 4'b0110;
            m_dyn[c]  = 4'b1001;
        end
    endfunction

    function automatic void model_write(input logic [3:0] a, input logic [3:0] d);
        for (int c = 0; c < NCH; c++) begin
            if (a == 4'(c * 9))     m_gen[c]  = d;
            if (a == 4'(c * 9 + 1)) m_rate[c] = d;
            if (a == 4'(c * 9 + 2)) m_dyn[c]  = {d[3:1], 1'b1};
        end
    endfunction

    // Monitor: compares one scoreboard item per falling clock edge.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            logic [19:0] act;
            e   = sb.pop_front();
            act = {misc_cfg, clk_sel, rate, bist_on, drv1_off, drv2_off, chan_off};
            checks++;
            if (act !== e.v) begin
                errors++;
                $display("FAIL %s: outputs actual %05h expected %05h", e.tag, act, e.v);
            end
        end
    end

    always @(negedge tx_clk[0]) if (recenter_pulse[0] === 1'b1) pcount[0]++;
    always @(negedge tx_clk[1]) if (recenter_pulse[1] === 1'b1) pcount[1]++;

    task automatic push_exp(input string tag);
        exp_t e;
        e.v   = model_vec();
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        dev_rst_n = 1'b0;
        wr_en     = 1'b0;
        repeat (6) @(posedge clk);
        #1;
        model_reset();
        push_exp(tag);
        @(negedge clk);
        dev_rst_n = 1'b1;
    endtask

    task automatic do_write(input logic [3:0] a, input logic [3:0] d, input bit en, input string tag);
        @(negedge clk);
        wr_en   = en;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        if (en) model_write(a, d);
        push_exp(tag);
    endtask

    task automatic check_pulses(input int e0, input int e1, input string tag);
        repeat (80) @(posedge clk);
        @(negedge clk);
        checks++;
        if (pcount[0] != e0 || pcount[1] != e1) begin
            errors++;
            $display("FAIL %s: pulse counts actual %0d/%0d expected %0d/%0d",
                     tag, pcount[0], pcount[1], e0, e1);
        end
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        pcount[0] = 0;
        pcount[1] = 0;
        dev_rst_n = 1'b0;
        wr_en     = 1'b0;
        wr_addr   = '0;
        wr_data   = '0;
        model_reset();

        do_reset("R2 reset defaults");
        check_pulses(0, 0, "R2 no pulse after reset");

        // R1 R3: static slots of both channels
        do_write(4'd0,  4'b1010, 1'b1, "R1 R3 ch0 general slot");
        do_write(4'd1,  4'b0010, 1'b1, "R3 ch0 clk_sel=1 rate=0");
        do_write(4'd9,  4'b0101, 1'b1, "R1 R3 ch1 general slot");
        do_write(4'd10, 4'b1101, 1'b1, "R3 ch1 clk_sel=0 rate=1");
        do_write(4'd1,  4'b1101, 1'b1, "R3 ch0 clk_sel=0 rate=1");

        // R4 R5 R9: dynamic slot, bit0 kept at 1
        do_write(4'd2, 4'b0111, 1'b1, "R4 R5 ch0 bist on both drivers on");
        check_pulses(0, 0, "R9 bit0=1 gives no pulse");

        // R8: request on ch0 with only secondary driver
        do_write(4'd2, 4'b1100, 1'b1, "R5 ch0 secondary only");
        check_pulses(1, 0, "R8 one pulse ch0");

        // R6 R8: both drivers off, second request after self-clear
        do_write(4'd2, 4'b1000, 1'b1, "R6 ch0 both drivers off");
        check_pulses(2, 0, "R8 self-clear second pulse ch0");

        // R5 R8: ch1 primary only, request
        do_write(4'd11, 4'b1010, 1'b1, "R5 ch1 primary only");
        check_pulses(2, 1, "R8 one pulse ch1 only");

        // R7: undecoded addresses and idle strobe
        for (int a = 3; a <= 8; a++)
            do_write(4'(a), 4'b0000, 1'b1, "R7 undecoded low range");
        for (int a = 12; a <= 15; a++)
            do_write(4'(a), 4'b0000, 1'b1, "R7 undecoded high range");
        do_write(4'd2,  4'b0110, 1'b0, "R7 strobe low ch0 dyn");
        do_write(4'd11, 4'b0000, 1'b0, "R7 strobe low ch1 dyn");
        do_write(4'd0,  4'b0000, 1'b0, "R7 strobe low ch0 general");
        check_pulses(2, 1, "R7 no pulse from ignored writes");

        // R2: reset from a loaded state
        do_write(4'd11, 4'b0111, 1'b1, "R4 ch1 bist on drivers on");
        do_reset("R2 reset from loaded state");

        // R8 after reset, ch1 again
        do_write(4'd11, 4'b1000, 1'b1, "R6 ch1 both drivers off");
        check_pulses(2, 2, "R8 pulse ch1 after reset");

        repeat (4) @(posedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule